// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single timer channel. It takes a base tick strobe (nominally one pulse every 250 ns) and divides it down to a selectable resolution. At that resolution it steps a 16-bit counter. The counter can run down towards zero or up towards a programmed limit. It can stop after one pass or reload itself and run again. When the counter reaches its terminal value, the channel raises a one-cycle event and sets a sticky done flag.

Software-side logic drives the channel through a small command port. A setup command sets the direction, the repeat mode, the resolution and the count. Other commands load a new count, start, stop, load-and-start, and take a snapshot of the live counter into a hold register. The hold register is visible on the count output.

The channel validates every count it is given. It refuses a bad resolution, a bad count, or a load while it is counting. A refused command raises a one-cycle error pulse and changes nothing.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset the channel is stopped, and `running_o`, `done_o`, `tc_o`, `err_o` and `count_o` are all 0.
- R2: The resolution is the number of base ticks per counter step. A setup accepts only 4, 40, 400, 4000 or 40000. Any other value is refused with an error pulse.
- R3: In down mode the counter starts at the load value L. The terminal event arrives once exactly L×D base ticks have been counted while running, where D is the resolution. The counter then holds 0 (one-shot).
- R4: In up mode the counter starts at 0 and reaches the terminal event when it equals L, after L×D base ticks. In one-shot mode it then holds L.
- R5: With the repeat bit set, the terminal event reloads the counter (L for down, 0 for up). The channel keeps running and produces an event every L×D base ticks.
- R6: Without the repeat bit, the terminal event clears `running_o`. The counter keeps its terminal value.
- R7: A count of 0 is always refused. A count of 1 is refused when repeat mode is in effect (for a setup, the repeat bit given with it). A refused count raises `err_o` for one cycle and leaves the count and configuration unchanged.
- R8: A load-count or setup command issued while the channel is running is refused with an error pulse. The running count is left unchanged.
- R9: A load-and-start command writes the load register, reinitialises the counter, clears the prescaler and starts counting in one operation. It is accepted while running and restarts the interval.
- R10: A snapshot command copies the live counter into the hold register, replacing its previous value. The hold register drives `count_o` from the next cycle until the next snapshot.
- R11: `tc_o` is high for exactly one cycle per terminal event. `done_o` is set by each terminal event and cleared by the next accepted start or load-and-start.
- R12: Stop freezes the counter. Base ticks have no effect while the channel is stopped. Start resumes from the frozen count with a cleared prescaler, or reloads when the counter sits at its terminal value. Start before any valid count has been loaded is refused with an error pulse.
- R13: The command code on `cmd_op_i` is: 0 no-op, 1 setup, 2 load count, 3 load-and-start, 4 start, 5 stop, 6 snapshot. Code 7 is refused with an error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base tick strobe, one cycle per 250 ns |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (R13) |
| cmd_count_i | input | 16 | Count value for setup, load and load-and-start |
| cmd_up_i | input | 1 | Setup only: 1 counts up, 0 counts down |
| cmd_repeat_i | input | 1 | Setup only: 1 selects repeating operation |
| cmd_res_i | input | 16 | Setup only: base ticks per counter step |
| running_o | output | 1 | Channel is counting |
| done_o | output | 1 | Sticky terminal-count flag |
| tc_o | output | 1 | One-cycle terminal-count event |
| err_o | output | 1 | One-cycle pulse for a refused command |
| count_o | output | 16 | Hold register (last snapshot) |

## Verification
The hardest situation to reach from the ports is a command that lands in the middle of an interval while the prescaler holds a partial count. Examples are a load-and-start that must discard the partial prescale, and a stop and restart that must discard it on resume. The stimulus drives an exact, known number of base ticks that is not a multiple of the resolution before it issues the command. It then takes a snapshot to read the frozen count, and counts the base ticks up to the next terminal event. Randomised intervals with sparse, irregular ticks check every mode combination against the L×D rule.

// File: rtl/itc_pkg.sv
package itc_pkg;

   typedef enum logic [2:0] {
      OP_NOP    = 3'd0,
      OP_SETUP  = 3'd1,
      OP_LOAD   = 3'd2,
      OP_MODIFY = 3'd3,
      OP_START  = 3'd4,
      OP_STOP   = 3'd5,
      OP_SNAP   = 3'd6,
      OP_RSVD   = 3'd7
   } itc_op_e;

endpackage

// File: rtl/itc_prescaler.sv
module itc_prescaler #(
   parameter int PRE_W   = 16,
   parameter bit ENABLE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             tick,
   input  logic [PRE_W-1:0] div,
   output logic             step
);

   localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

   generate
      if (ENABLE) begin : g_div
         logic [PRE_W-1:0] presc_q;
         logic             wrap;

         assign wrap = (presc_q == div - ONE);
         assign step = run & tick & wrap;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           presc_q <= '0;
            else if (clr)         presc_q <= '0;
            else if (run && tick) presc_q <= wrap ? '0 : presc_q + ONE;
         end

         AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            run |-> (presc_q < div)); // R2
      end else begin : g_bypass
         logic unused_ok;
         assign unused_ok = clr ^ (^div);
         assign step = run & tick;
      end
   endgenerate

endmodule

// File: rtl/itc_ctrl.sv
module itc_ctrl
   import itc_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int PRE_W    = 16,
   parameter int BASE_DIV = 4,
   parameter int NUM_RES  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic [CNT_W-1:0] cmd_count,
   input  logic             cmd_up,
   input  logic             cmd_rep,
   input  logic [PRE_W-1:0] cmd_res,
   input  logic [CNT_W-1:0] load_q,
   input  logic             at_term,
   input  logic             tc_fire,
   output logic             run_q,
   output logic             up_q,
   output logic             rep_q,
   output logic [PRE_W-1:0] div_q,
   output logic             ld_en,
   output logic             init_up,
   output logic             restart,
   output logic             presc_clr,
   output logic             snap_en,
   output logic             err_q,
   output logic             done_q
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   function automatic logic res_ok(input logic [PRE_W-1:0] r);
      logic [31:0] m;
      logic        hit;
      m   = 32'(BASE_DIV);
      hit = 1'b0;
      for (int k = 0; k < NUM_RES; k++) begin
         if (32'(r) == m) hit = 1'b1;
         m = m * 32'd10;
      end
      return hit;
   endfunction

   function automatic logic cnt_ok(input logic [CNT_W-1:0] c, input logic rep);
      return (c != '0) && !(rep && (c == CNT_ONE));
   endfunction

   itc_op_e op;
   logic    set_cfg, go, halt, bad;

   assign op = itc_op_e'(cmd_op);

   always_comb begin
      set_cfg = 1'b0;
      go      = 1'b0;
      halt    = 1'b0;
      bad     = 1'b0;
      ld_en   = 1'b0;
      restart = 1'b0;
      snap_en = 1'b0;
      if (cmd_valid) begin
         case (op)
            OP_SETUP: begin
               if (!run_q && res_ok(cmd_res) && cnt_ok(cmd_count, cmd_rep)) begin
                  set_cfg = 1'b1;
                  ld_en   = 1'b1;
               end else bad = 1'b1;
            end
            OP_LOAD: begin
               if (!run_q && cnt_ok(cmd_count, rep_q)) ld_en = 1'b1;
               else bad = 1'b1;
            end
            OP_MODIFY: begin
               if (cnt_ok(cmd_count, rep_q)) begin
                  ld_en = 1'b1;
                  go    = 1'b1;
               end else bad = 1'b1;
            end
            OP_START: begin
               if (load_q == '0) bad = 1'b1;
               else if (!run_q) begin
                  go      = 1'b1;
                  restart = at_term;
               end
            end
            OP_STOP:  halt    = 1'b1;
            OP_SNAP:  snap_en = 1'b1;
            OP_RSVD:  bad     = 1'b1;
            default:  ;
         endcase
      end
   end

   assign init_up   = set_cfg ? cmd_up : up_q;
   assign presc_clr = go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         up_q   <= 1'b0;
         rep_q  <= 1'b0;
         div_q  <= PRE_W'(BASE_DIV);
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         err_q <= bad;
         if (go)                     run_q <= 1'b1;
         else if (halt)              run_q <= 1'b0;
         else if (tc_fire && !rep_q) run_q <= 1'b0;
         if (go)           done_q <= 1'b0;
         else if (tc_fire) done_q <= 1'b1;
         if (set_cfg) begin
            up_q  <= cmd_up;
            rep_q <= cmd_rep;
            div_q <= cmd_res;
         end
      end
   end

   AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_fire && !rep_q) |=> !run_q); // R6
   AST_BUSY_LOAD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_LOAD && run_q) |=> err_q); // R8
   AST_ZERO_COUNT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_SETUP && cmd_count == '0) |=> err_q); // R7
   AST_DONE_ON_TC: assert property (@(posedge clk) disable iff (!rst_n)
      tc_fire |=> done_q); // R11

endmodule

// File: rtl/itc_counter.sv
module itc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic             up,
   input  logic             rep,
   input  logic             ld_en,
   input  logic             init_up,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             restart,
   input  logic             snap_en,
   output logic [CNT_W-1:0] load_q,
   output logic [CNT_W-1:0] hold_q,
   output logic             at_term,
   output logic             tc_fire,
   output logic             tc_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             hit;

   assign cnt_nxt = up ? cnt_q + ONE : cnt_q - ONE;
   assign hit     = up ? (cnt_nxt == load_q) : (cnt_q == ONE);
   assign tc_fire = step & hit & ~ld_en & ~restart;
   assign at_term = up ? (cnt_q == load_q) : (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         load_q <= '0;
         hold_q <= '0;
         tc_q   <= 1'b0;
      end else begin
         tc_q <= tc_fire;
         if (snap_en) hold_q <= cnt_q;
         if (ld_en) begin
            load_q <= ld_val;
            cnt_q  <= init_up ? '0 : ld_val;
         end else if (restart) begin
            cnt_q  <= up ? '0 : load_q;
         end else if (step) begin
            if (hit && rep) cnt_q <= up ? '0 : load_q;
            else            cnt_q <= cnt_nxt;
         end
      end
   end

   AST_TC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tc_q |=> !tc_q); // R11
   AST_UP_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (run && up) |-> (cnt_q < load_q)); // R4
   AST_DOWN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !up) |-> (cnt_q != '0)); // R3
   AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld_en && !restart) |=> $stable(cnt_q)); // R12

endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
   import itc_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int PRE_W    = 16,
   parameter int BASE_DIV = 4,
   parameter int NUM_RES  = 5,
   parameter bit PRESCALE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             cmd_valid_i,
   input  logic [2:0]       cmd_op_i,
   input  logic [CNT_W-1:0] cmd_count_i,
   input  logic             cmd_up_i,
   input  logic             cmd_repeat_i,
   input  logic [PRE_W-1:0] cmd_res_i,
   output logic             running_o,
   output logic             done_o,
   output logic             tc_o,
   output logic             err_o,
   output logic [CNT_W-1:0] count_o
);

   localparam longint MAX_DIV = longint'(BASE_DIV) * (10 ** (NUM_RES - 1));

   initial begin
      AST_CFG_CNT_W: assert (CNT_W >= 2 && CNT_W <= 32) else $fatal(1, "CNT_W out of range"); // R3
      AST_CFG_DIV_FITS: assert (MAX_DIV < (longint'(1) << PRE_W)) else $fatal(1, "PRE_W too narrow"); // R2
      AST_CFG_BASE: assert (BASE_DIV >= 2) else $fatal(1, "BASE_DIV too small"); // R2
   end

   logic             run, up, rep, ld_en, init_up, restart, presc_clr, snap_en;
   logic             step, at_term, tc_fire;
   logic [PRE_W-1:0] div;
   logic [CNT_W-1:0] load_q;

   itc_ctrl #(
      .CNT_W(CNT_W), .PRE_W(PRE_W), .BASE_DIV(BASE_DIV), .NUM_RES(NUM_RES)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid_i), .cmd_op(cmd_op_i), .cmd_count(cmd_count_i),
      .cmd_up(cmd_up_i), .cmd_rep(cmd_repeat_i), .cmd_res(cmd_res_i),
      .load_q(load_q), .at_term(at_term), .tc_fire(tc_fire),
      .run_q(run), .up_q(up), .rep_q(rep), .div_q(div),
      .ld_en(ld_en), .init_up(init_up), .restart(restart),
      .presc_clr(presc_clr), .snap_en(snap_en),
      .err_q(err_o), .done_q(done_o)
   );

   itc_prescaler #(.PRE_W(PRE_W), .ENABLE(PRESCALE)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(presc_clr), .run(run),
      .tick(tick_i), .div(div), .step(step)
   );

   itc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .step(step), .up(up), .rep(rep),
      .ld_en(ld_en), .init_up(init_up), .ld_val(cmd_count_i),
      .restart(restart), .snap_en(snap_en),
      .load_q(load_q), .hold_q(count_o), .at_term(at_term),
      .tc_fire(tc_fire), .tc_q(tc_o)
   );

   assign running_o = run;

   AST_REPEAT_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_fire && rep && !(cmd_valid_i && cmd_op_i == OP_STOP)) |=> running_o); // R5

endmodule

// File: tb/interval_timer_channel_tb.sv
module interval_timer_channel_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        cv = 1'b0;
   logic [2:0]  cop = '0;
   logic [15:0] ccnt = '0;
   logic        cup = 1'b0;
   logic        crep = 1'b0;
   logic [15:0] cres = '0;
   logic        running, done, tc, err;
   logic [15:0] count;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   interval_timer_channel u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .cmd_valid_i(cv), .cmd_op_i(cop), .cmd_count_i(ccnt),
      .cmd_up_i(cup), .cmd_repeat_i(crep), .cmd_res_i(cres),
      .running_o(running), .done_o(done), .tc_o(tc), .err_o(err), .count_o(count)
   );

   function automatic int exp_ticks(input int len, input int dv);
      return len * dv;
   endfunction

   function automatic int exp_term(input bit up_m, input int len);
      return up_m ? len : 0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cmd(input int op, input int c = 0, input bit u = 0,
                      input bit r = 0, input int rs = 4);
      @(negedge clk);
      tick = 1'b0; cv = 1'b1; cop = 3'(op); ccnt = 16'(c);
      cup = u; crep = r; cres = 16'(rs);
      @(negedge clk);
      cv = 1'b0; cop = '0;
   endtask

   task automatic ticks_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
      end
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic run_tc(output int nt);
      nt = 0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         tick = 1'b0;
         if (tc) break;
         if (($urandom % 4) != 0) begin tick = 1'b1; nt++; end
      end
      @(negedge clk);
      chk("R11 tc one cycle", int'(tc), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int nt;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 running", int'(running), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 tc", int'(tc), 0);
      chk("R1 err", int'(err), 0);
      chk("R1 count", int'(count), 0);

      cmd(4); chk("R12 start unloaded", int'(err), 1);
      chk("R12 still stopped", int'(running), 0);
      cmd(7); chk("R13 reserved op", int'(err), 1);
      cmd(0); chk("R13 nop", int'(err), 0);

      cmd(1, 5, 0, 0, 5);     chk("R2 bad res", int'(err), 1);
      cmd(1, 5, 0, 0, 40000); chk("R2 res 40000", int'(err), 0);
      cmd(1, 0, 0, 0, 4);     chk("R7 zero count", int'(err), 1);
      cmd(1, 1, 0, 1, 4);     chk("R7 one repeat", int'(err), 1);
      cmd(1, 1, 0, 0, 4);     chk("R7 one oneshot", int'(err), 0);

      // R3 down one-shot
      cmd(1, 5, 0, 0, 4); cmd(4);
      chk("R3 running", int'(running), 1);
      run_tc(nt);
      chk("R3 ticks", nt, exp_ticks(5, 4));
      chk("R11 done set", int'(done), 1);
      chk("R6 stopped", int'(running), 0);
      cmd(6); chk("R6 down terminal", int'(count), exp_term(0, 5));

      // R12 start at terminal reloads; done cleared by start
      cmd(4); chk("R11 done cleared", int'(done), 0);
      run_tc(nt); chk("R12 reload at terminal", nt, exp_ticks(5, 4));

      // R4 up one-shot
      cmd(1, 6, 1, 0, 4); cmd(4);
      run_tc(nt); chk("R4 ticks", nt, exp_ticks(6, 4));
      cmd(6); chk("R4 up terminal", int'(count), exp_term(1, 6));

      // R2 resolution 400
      cmd(1, 2, 0, 0, 400); cmd(4);
      run_tc(nt); chk("R2 res 400 ticks", nt, exp_ticks(2, 400));

      // R5 repeat down
      cmd(1, 3, 0, 1, 40); cmd(4);
      run_tc(nt); chk("R5 period 1", nt, exp_ticks(3, 40));
      chk("R5 running", int'(running), 1);
      run_tc(nt); chk("R5 period 2", nt, exp_ticks(3, 40));
      cmd(5); chk("R12 stop", int'(running), 0);

      // R8 load while running refused
      cmd(1, 8, 0, 0, 4); cmd(4);
      cmd(2, 2); chk("R8 load busy err", int'(err), 1);
      cmd(1, 2, 0, 0, 4); chk("R8 setup busy err", int'(err), 1);
      run_tc(nt); chk("R8 count unchanged", nt, exp_ticks(8, 4));

      // R9 load-and-start while running
      cmd(1, 10, 0, 0, 4); cmd(4);
      ticks_n(5);
      cmd(3, 3); chk("R9 accepted", int'(err), 0);
      chk("R9 running", int'(running), 1);
      run_tc(nt); chk("R9 restarted", nt, exp_ticks(3, 4));

      // R10 / R12 stop, snapshot, resume
      cmd(1, 10, 0, 0, 4); cmd(4);
      ticks_n(13);
      cmd(5); cmd(6); chk("R10 snapshot", int'(count), 7);
      ticks_n(10);
      cmd(6); chk("R12 frozen", int'(count), 7);
      cmd(4); run_tc(nt); chk("R12 resume", nt, exp_ticks(7, 4));

      // random mix
      for (int it = 0; it < 16; it++) begin
         int  len, dv;
         bit  u, r;
         len = 2 + int'($urandom % 10);
         dv  = (($urandom % 2) != 0) ? 40 : 4;
         u   = 1'($urandom % 2);
         r   = 1'($urandom % 2);
         cmd(5);
         cmd(1, len, u, r, dv); chk("R7 valid setup", int'(err), 0);
         cmd(4);
         run_tc(nt); chk(u ? "R4 random" : "R3 random", nt, exp_ticks(len, dv));
         if (r) begin
            chk("R5 random running", int'(running), 1);
            run_tc(nt); chk("R5 random period", nt, exp_ticks(len, dv));
            cmd(5);
         end else begin
            chk("R6 random stopped", int'(running), 0);
            cmd(6); chk("R10 random terminal", int'(count), exp_term(u, len));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule